// File: doc/BRIEF.md
# Remappable Address Map Decoder

This block sits on a 32-bit byte-addressed bus. It takes an address and an access size and picks one target: on-chip SRAM, flash, or the peripheral register space. It also gives the offset inside that target and the little-endian byte-lane enables. The offset and enables are ready to pass to the memory arrays, which are outside this block.

The lowest 32 kB of the address space is a window that can show either flash or SRAM. A single remap bit, held in a small register with a write strobe, chooses which memory the window shows. Three kinds of access raise a data-abort flag and select no target: an address that falls in a gap of the map, a misaligned access, and a reserved size code.

The decode path is purely combinational. Only the remap bit is stored.

Top module: `mmap_decoder`

## Requirements
- R1: After reset the remap bit is 0, so a word access at 0x00000100 selects flash (sel = 3'b010) with offset 0x0100.
- R2: With remap at 0, any address from 0x00000000 to 0x00007FFF selects flash (sel = 3'b010), and the offset is addr[15:0].
- R3: With remap at 1, addresses 0x00000000 to 0x00000FFF select SRAM (sel = 3'b001) with offset addr[15:0]. Addresses 0x00001000 to 0x00007FFF abort.
- R4: Addresses 0x00040000 to 0x00040FFF select SRAM (sel = 3'b001) with offset addr - 0x00040000, whatever the remap bit holds.
- R5: Addresses 0x00080000 to 0x00087FFF select flash (sel = 3'b010) with offset addr - 0x00080000.
- R6: Addresses 0xFFFF0000 to 0xFFFFFFFF select the register space (sel = 3'b100) with offset addr[15:0].
- R7: Any address outside the regions above raises abort. Whenever abort is high, sel, offset and byte_en are all zero.
- R8: A byte access (size 2'b00) drives byte_en = 4'b0001 << addr[1:0]. Lane 0 is the lowest byte address.
- R9: A halfword access (size 2'b01) with addr[0] = 0 enables lanes 1:0 (4'b0011) when addr[1] = 0, and lanes 3:2 (4'b1100) when addr[1] = 1. A halfword access with addr[0] = 1 aborts.
- R10: A word access (size 2'b10) with addr[1:0] = 0 drives byte_en = 4'b1111. A word access with any other low bits aborts. Size 2'b11 always aborts.
- R11: When remap_we is high at a rising clock edge, the remap bit takes remap_wd. Otherwise it keeps its value.
- R12: sel is one-hot or zero, and abort is high exactly when sel is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the remap register |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_we | input | 1 | Write strobe for the remap bit |
| remap_wd | input | 1 | New remap value (1 = SRAM in low window) |
| bus_addr | input | 32 | Byte address of the access |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| sel | output | 3 | Region select: bit0 SRAM, bit1 flash, bit2 registers |
| offset | output | 16 | Byte offset inside the selected region |
| byte_en | output | 4 | Little-endian byte-lane enables |
| abort | output | 1 | Data-abort flag |

## Verification
The select, offset, byte-enable and abort outputs depend only on the address, the size and the stored remap bit, with no register on the path. The bench therefore drives each access on a falling clock edge and samples a short delay later, inside the same cycle. A remap write appears at the outputs only after the rising edge that captures it. For that reason the bench drives the strobe at a falling edge, lets one rising edge pass, and checks the window decode at the next falling edge. It also checks that a cycle with the strobe low leaves the window decode unchanged.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NREG      = 3;
  localparam int REG_SRAM  = 0;
  localparam int REG_FLASH = 1;
  localparam int REG_MMR   = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/mmap_remap_reg.sv
module mmap_remap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wd,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R11
  remap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wd)));

  // R11
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                OFF_W      = 16,
  parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h0004_0000,
  parameter logic [ADDR_W-1:0] SRAM_SIZE  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0008_0000,
  parameter logic [ADDR_W-1:0] FLASH_SIZE = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] MMR_BASE   = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] MMR_SIZE   = 32'h0001_0000
) (
  input  logic              remap,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic [OFF_W-1:0]  off,
  output logic              hole
);
  logic [NREG-1:0]   hit;
  logic [OFF_W-1:0]  hit_off [NREG];
  logic              in_win;
  logic              in_win_sram;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] B =
      (i == REG_SRAM) ? SRAM_BASE : (i == REG_FLASH) ? FLASH_BASE : MMR_BASE;
    localparam logic [ADDR_W-1:0] S =
      (i == REG_SRAM) ? SRAM_SIZE : (i == REG_FLASH) ? FLASH_SIZE : MMR_SIZE;
    logic [ADDR_W-1:0] delta;
    assign delta      = addr - B;
    assign hit[i]     = (addr >= B) && (delta < S);
    assign hit_off[i] = delta[OFF_W-1:0];
  end

  assign in_win      = (addr < WIN_SIZE);
  assign in_win_sram = (addr < SRAM_SIZE);

  always_comb begin
    sel = '0;
    off = '0;
    if (in_win) begin
      if (!remap) begin
        sel[REG_FLASH] = 1'b1;
        off            = addr[OFF_W-1:0];
      end else if (in_win_sram) begin
        sel[REG_SRAM] = 1'b1;
        off           = addr[OFF_W-1:0];
      end
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (hit[k]) begin
          sel[k] = 1'b1;
          off    = hit_off[k];
        end
      end
    end
  end

  assign hole = (sel == '0);
endmodule

// File: rtl/mmap_lane_gen.sv
module mmap_lane_gen
  import mmap_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] lo,
  output logic [3:0] be,
  output logic       bad
);
  always_comb begin
    be  = 4'b0000;
    bad = 1'b0;
    case (acc_size_e'(size))
      SZ_BYTE: be = 4'b0001 << lo;
      SZ_HALF: begin
        bad = lo[0];
        be  = lo[1] ? 4'b1100 : 4'b0011;
      end
      SZ_WORD: begin
        bad = (lo != 2'b00);
        be  = 4'b1111;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remap_we,
  input  logic              remap_wd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output logic [NREG-1:0]   sel,
  output logic [OFF_W-1:0]  offset,
  output logic [3:0]        byte_en,
  output logic              abort
);
  localparam logic [ADDR_W-1:0] WIN_TOP  = 32'h0000_8000;
  localparam logic [ADDR_W-1:0] SRAM_TOP = 32'h0000_1000;

  logic              remap_q;
  logic [NREG-1:0]   r_sel;
  logic [OFF_W-1:0]  r_off;
  logic              r_hole;
  logic [3:0]        l_be;
  logic              l_bad;

  mmap_remap_reg u_remap (
    .clk (clk),
    .rst_n (rst_n),
    .we (remap_we),
    .wd (remap_wd),
    .q (remap_q)
  );

  mmap_region_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_region (
    .remap (remap_q),
    .addr (bus_addr),
    .sel (r_sel),
    .off (r_off),
    .hole (r_hole)
  );

  mmap_lane_gen u_lanes (
    .size (bus_size),
    .lo (bus_addr[1:0]),
    .be (l_be),
    .bad (l_bad)
  );

  always_comb begin
    abort   = r_hole | l_bad;
    sel     = abort ? '0 : r_sel;
    offset  = abort ? '0 : r_off;
    byte_en = abort ? 4'b0000 : l_be;
  end

  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (abort == (sel == '0)));

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (byte_en == 4'b0000) && (offset == '0));

  // R3
  win_sram_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_q && (bus_addr >= SRAM_TOP) && (bus_addr < WIN_TOP)) |-> abort);

  // R2
  win_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!remap_q && (bus_addr < WIN_TOP) && !abort) |-> (sel == 3'b010));

  // R8
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_size == 2'b00) && !abort) |-> ($countones(byte_en) == 1));

  // R10
  word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_size == 2'b10) && !abort) |-> (byte_en == 4'b1111));
endmodule

// File: tb/mmap_decoder_tb.sv
module mmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        remap_we;
  logic        remap_wd;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [2:0]  sel;
  logic [15:0] offset;
  logic [3:0]  byte_en;
  logic        abort;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  tb_rm   = 1'b0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  mmap_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .remap_we (remap_we), .remap_wd (remap_wd),
    .bus_addr (bus_addr), .bus_size (bus_size), .sel (sel), .offset (offset),
    .byte_en (byte_en), .abort (abort)
  );

  function automatic void model(input logic [31:0] a, input logic [1:0] sz, input bit rm,
                                output logic [2:0] s, output logic [15:0] o,
                                output logic [3:0] be, output bit ab);
    s = 3'b000; o = 16'h0; be = 4'h0; ab = 1'b0;
    if (a < 32'h8000) begin
      if (!rm) begin s = 3'b010; o = a[15:0]; end
      else if (a < 32'h1000) begin s = 3'b001; o = a[15:0]; end
      else ab = 1'b1;
    end else if (a >= 32'h40000 && a <= 32'h40FFF) begin
      s = 3'b001; o = 16'(a - 32'h40000);
    end else if (a >= 32'h80000 && a <= 32'h87FFF) begin
      s = 3'b010; o = 16'(a - 32'h80000);
    end else if (a >= 32'hFFFF0000) begin
      s = 3'b100; o = a[15:0];
    end else ab = 1'b1;
    case (sz)
      2'b00: be = 4'b0001 << a[1:0];
      2'b01: begin if (a[0]) ab = 1'b1; be = a[1] ? 4'b1100 : 4'b0011; end
      2'b10: begin if (a[1:0] != 2'b00) ab = 1'b1; be = 4'b1111; end
      default: ab = 1'b1;
    endcase
    if (ab) begin s = 3'b000; o = 16'h0; be = 4'h0; end
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input string tag);
    logic [2:0] es; logic [15:0] eo; logic [3:0] eb; bit ea;
    @(negedge clk);
    bus_addr = a; bus_size = sz;
    #1;
    model(a, sz, tb_rm, es, eo, eb, ea);
    n_tests++;
    if (sel !== es || offset !== eo || byte_en !== eb || abort !== ea) begin
      n_fail++;
      $display("FAIL %s addr=%h size=%0d: got sel=%b off=%h be=%b ab=%b, expected sel=%b off=%h be=%b ab=%b",
               tag, a, sz, sel, offset, byte_en, abort, es, eo, eb, ea);
    end
  endtask

  task automatic set_remap(input bit v);
    @(negedge clk);
    remap_we = 1'b1; remap_wd = v;
    @(negedge clk);
    remap_we = 1'b0; remap_wd = ~v;
    tb_rm = v;
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] r = $urandom;
    case ($urandom_range(0, 6))
      0: return {17'h0, r[14:0]};
      1: return 32'h40000 + {20'h0, r[11:0]};
      2: return 32'h80000 + {17'h0, r[14:0]};
      3: return {16'hFFFF, r[15:0]};
      4: return 32'h40000 + {19'h0, r[12:0]};
      5: return 32'h80000 + {16'h0, r[15:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; remap_we = 1'b0; remap_wd = 1'b0;
    bus_addr = 32'h0; bus_size = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    access(32'h0000_0100, 2'b10, "R1");
    access(32'h0000_7FFC, 2'b10, "R2");
    access(32'h0000_1235, 2'b00, "R2");
    access(32'h0000_8000, 2'b10, "R7");
    access(32'h0004_0000, 2'b10, "R4");
    access(32'h0004_0FFE, 2'b01, "R4");
    access(32'h0004_1000, 2'b00, "R7");
    access(32'h0003_FFFF, 2'b00, "R7");
    access(32'h0008_0000, 2'b00, "R5");
    access(32'h0008_7FFF, 2'b00, "R5");
    access(32'h0008_8000, 2'b10, "R7");
    access(32'hFFFF_0000, 2'b10, "R6");
    access(32'hFFFF_FFFF, 2'b00, "R6");
    access(32'hFFFE_FFFC, 2'b10, "R7");
    for (int i = 0; i < 4; i++) access(32'h0004_0010 + i, 2'b00, "R8");
    access(32'h0004_0012, 2'b01, "R9");
    access(32'h0004_0010, 2'b01, "R9");
    access(32'h0004_0011, 2'b01, "R9");
    access(32'h0004_0013, 2'b01, "R9");
    access(32'h0004_0012, 2'b10, "R10");
    access(32'h0004_0001, 2'b10, "R10");
    access(32'h0004_0010, 2'b11, "R10");

    set_remap(1'b1);
    access(32'h0000_0000, 2'b10, "R11");
    access(32'h0000_0FFC, 2'b10, "R3");
    access(32'h0000_1000, 2'b10, "R3");
    access(32'h0000_7FFF, 2'b00, "R3");
    access(32'h0004_0020, 2'b10, "R4");
    @(negedge clk); remap_we = 1'b0; remap_wd = 1'b0;
    @(negedge clk);
    access(32'h0000_0FFC, 2'b10, "R11");
    set_remap(1'b0);
    access(32'h0000_1000, 2'b10, "R11");

    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 250) set_remap(~tb_rm);
      access(pick_addr(), 2'($urandom_range(0, 3)), "R12");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule